// File: doc/BRIEF.md
# Snooping Three-State Cache Coherence Controller

This block models a small shared-bus multiprocessor memory system. Each of `N_CPU` processor ports has its own direct-mapped cache. Every line of that cache carries a tag, a data word and one of three states: Invalid, Shared (clean copy) or Exclusive (the only copy, possibly dirty). A processor issues single-word reads and writes. Reads that find the line Shared or Exclusive, and writes that find the line Exclusive, finish inside the local cache. Everything else goes through a single shared bus.

The bus is granted to one controller per cycle by a round-robin arbiter. Each granted cycle is one atomic transaction that every other controller snoops in the same cycle. There are two transaction kinds. A read-for-share (`rdx`=0) leaves the requester Shared and demotes any Exclusive holder to Shared. A read-for-ownership (`rdx`=1) makes the requester Exclusive and invalidates every other copy. Fill data comes from the Exclusive holder when one exists, and otherwise from a flat word-addressed memory model. In the same cycle, a dirty victim being evicted and a dirty supplier are both written back to memory. A bus-transaction counter lets a bench add up the traffic a given access pattern costs.

An address splits into a low `IDX_W`-bit line index and a high tag. Each controller steps through `CT_IDLE`, `CT_LOOKUP`, `CT_WAIT` and `CT_RESP`:
- `CT_IDLE` moves to `CT_LOOKUP` when a request pulse arrives.
- `CT_LOOKUP` moves to `CT_RESP` on a local hit, or to `CT_WAIT` on a miss.
- `CT_LOOKUP` stays where it is while another controller's transaction snoops the same line index.
- `CT_WAIT` moves to `CT_RESP` in its grant cycle.
- `CT_RESP` pulses done and returns to `CT_IDLE`.

Line states are `LN_INV`, `LN_SHR` and `LN_EXC`.

Top module: `coh_snoop_top`

## Requirements
- R1: After reset, every line is Invalid, every memory word is zero, `bus_txn_count` is zero and no `cpu_done` bit is high.
- R2: For any address, at most one cache holds it Exclusive. During a transaction, at most one snooper reports ownership of the bus address.
- R3: A read whose line is Shared or Exclusive with a matching tag completes with the cached word and causes no bus transaction.
- R4: A write whose line is Exclusive with a matching tag completes locally and causes no bus transaction.
- R5: A write that misses, or that finds the line Shared, costs exactly one transaction. It leaves the writer Exclusive and invalidates all other copies, so their next read of that address misses.
- R6: A read miss costs exactly one transaction and leaves the reader Shared. A former Exclusive holder keeps the line as Shared: its next read is a hit, and its next write needs the bus.
- R7: Read-miss data is the Exclusive holder's word when one exists, and otherwise the memory word.
- R8: When an Exclusive holder supplies data, its word is written to memory in the same transaction.
- R9: The arbiter grants at most one requesting controller per cycle, in round-robin order, so simultaneous requesters all complete.
- R10: `bus_txn_count` rises by exactly one per bus transaction and holds otherwise.
- R11: A miss that maps onto a line held Exclusive under a different tag writes that victim word back to memory in the same transaction that fetches the new line.
- R12: A request is a one-cycle `cpu_req` pulse taken in `CT_IDLE`. Completion is a one-cycle `cpu_done` pulse with `cpu_rdata` valid; for a write, `cpu_rdata` is the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | N_CPU | Request pulse per processor |
| cpu_we | input | N_CPU | 1 = write, 0 = read, per processor |
| cpu_addr | input | N_CPU*ADDR_W | Word address per processor, processor i at bits [i*ADDR_W +: ADDR_W] |
| cpu_wdata | input | N_CPU*DATA_W | Write word per processor |
| cpu_done | output | N_CPU | Completion pulse per processor |
| cpu_rdata | output | N_CPU*DATA_W | Returned word per processor |
| bus_txn_count | output | CNT_W | Running count of bus transactions |

## Verification
The bench builds the block with three processors, four lines per cache, 6-bit addresses and 16-bit data. With these values, addresses 5, 9 and 13 share one line index, so conflict evictions of Shared and Exclusive victims occur within a few accesses. Three controllers allow an Exclusive holder, a reader and a third observer to coexist, which exposes supply from a dirty peer, memory writeback and invalidation of several copies. Exact transaction counts after each access separate local hits from bus traffic, and simultaneous requests from two and three processors exercise the round-robin arbiter.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        CT_IDLE   = 2'd0,
        CT_LOOKUP = 2'd1,
        CT_WAIT   = 2'd2,
        CT_RESP   = 2'd3
    } ctl_st_t;
endpackage

// File: rtl/coh_arbiter.sv
module coh_arbiter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] next_ptr;
    logic          found;

    always_comb begin
        int j;
        gnt      = '0;
        found    = 1'b0;
        next_ptr = ptr_q;
        for (int k = 0; k < N; k++) begin
            j = (int'(ptr_q) + k) % N;
            if (!found && req[j]) begin
                gnt[j]   = 1'b1;
                found    = 1'b1;
                next_ptr = PW'((j + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else if (found) ptr_q <= next_ptr;
    end
endmodule

// File: rtl/coh_memory.sv
module coh_memory #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wa_en,
    input  logic [ADDR_W-1:0] wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (wa_en) mem_q[wa_addr] <= wa_data;
            if (wb_en) mem_q[wb_addr] <= wb_data;
        end
    end
endmodule

// File: rtl/coh_cache.sv
module coh_cache
    import coh_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              req_rdx,
    output logic [ADDR_W-1:0] req_addr,
    output logic              vic_wb,
    output logic [ADDR_W-1:0] vic_addr,
    output logic [DATA_W-1:0] vic_data,
    input  logic              bus_valid,
    input  logic              bus_rdx,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              snp_own,
    output logic [DATA_W-1:0] snp_data
);
    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_st_t           st_q, st_d;
    line_st_t          ls_q [LINES];
    logic [TAG_W-1:0]  tg_q [LINES];
    logic [DATA_W-1:0] dt_q [LINES];

    logic              r_we;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic [DATA_W-1:0] rdata_q;

    logic [IDX_W-1:0]  idx, b_idx;
    logic [TAG_W-1:0]  tag, b_tag;
    logic              tag_hit, hit_rd, hit_wr, snooped, snp_match, conflict;

    assign idx     = r_addr[IDX_W-1:0];
    assign tag     = r_addr[ADDR_W-1:IDX_W];
    assign b_idx   = bus_addr[IDX_W-1:0];
    assign b_tag   = bus_addr[ADDR_W-1:IDX_W];
    assign tag_hit = (tg_q[idx] == tag);
    assign hit_rd  = tag_hit && (ls_q[idx] != LN_INV);
    assign hit_wr  = tag_hit && (ls_q[idx] == LN_EXC);

    assign snooped   = bus_valid && !bus_gnt;
    assign snp_match = snooped && (ls_q[b_idx] != LN_INV) && (tg_q[b_idx] == b_tag);
    assign conflict  = snooped && (b_idx == idx);

    // bus-facing outputs
    assign bus_req  = (st_q == CT_WAIT);
    assign req_rdx  = r_we;
    assign req_addr = r_addr;
    assign vic_wb   = (ls_q[idx] == LN_EXC) && !tag_hit;
    assign vic_addr = {tg_q[idx], idx};
    assign vic_data = dt_q[idx];
    assign snp_own  = snp_match && (ls_q[b_idx] == LN_EXC);
    assign snp_data = dt_q[b_idx];

    // processor-facing outputs
    assign cpu_done  = (st_q == CT_RESP);
    assign cpu_rdata = rdata_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CT_IDLE:   if (cpu_req) st_d = CT_LOOKUP;
            CT_LOOKUP: begin
                if (!conflict) st_d = (r_we ? hit_wr : hit_rd) ? CT_RESP : CT_WAIT;
            end
            CT_WAIT:   if (bus_gnt) st_d = CT_RESP;
            CT_RESP:   st_d = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CT_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_we    <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
            rdata_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                ls_q[i] <= LN_INV;
                tg_q[i] <= '0;
                dt_q[i] <= '0;
            end
        end else begin
            if (st_q == CT_IDLE && cpu_req) begin
                r_we    <= cpu_we;
                r_addr  <= cpu_addr;
                r_wdata <= cpu_wdata;
            end
            // snoop reaction to another controller's transaction
            if (snp_match) begin
                if (bus_rdx)                      ls_q[b_idx] <= LN_INV;
                else if (ls_q[b_idx] == LN_EXC)   ls_q[b_idx] <= LN_SHR;
            end
            // local hit
            if (st_q == CT_LOOKUP && !conflict) begin
                if (r_we && hit_wr) begin
                    dt_q[idx] <= r_wdata;
                    rdata_q   <= r_wdata;
                end else if (!r_we && hit_rd) begin
                    rdata_q   <= dt_q[idx];
                end
            end
            // own granted transaction: fill
            if (st_q == CT_WAIT && bus_gnt) begin
                tg_q[idx] <= tag;
                ls_q[idx] <= r_we ? LN_EXC : LN_SHR;
                dt_q[idx] <= r_we ? r_wdata : fill_data;
                rdata_q   <= r_we ? r_wdata : fill_data;
            end
        end
    end
endmodule

// File: rtl/coh_snoop_top.sv
module coh_snoop_top #(
    parameter int N_CPU  = 3,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CPU-1:0]         cpu_req,
    input  logic [N_CPU-1:0]         cpu_we,
    input  logic [N_CPU*ADDR_W-1:0]  cpu_addr,
    input  logic [N_CPU*DATA_W-1:0]  cpu_wdata,
    output logic [N_CPU-1:0]         cpu_done,
    output logic [N_CPU*DATA_W-1:0]  cpu_rdata,
    output logic [CNT_W-1:0]         bus_txn_count
);
    logic [N_CPU-1:0]  breq, gnt, rdx, vwb, sown;
    logic [ADDR_W-1:0] raddr [N_CPU];
    logic [ADDR_W-1:0] vaddr [N_CPU];
    logic [DATA_W-1:0] vdata [N_CPU];
    logic [DATA_W-1:0] sdata [N_CPU];

    logic              bus_valid, bus_rdx, src_vwb, sup_hit;
    logic [ADDR_W-1:0] bus_addr, src_vaddr;
    logic [DATA_W-1:0] src_vdata, sup_data, mem_rd, fill_data;
    logic [CNT_W-1:0]  cnt_q;

    coh_arbiter #(.N(N_CPU)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(breq), .gnt(gnt)
    );

    for (genvar g = 0; g < N_CPU; g++) begin : g_cache
        coh_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cache (
            .clk(clk), .rst_n(rst_n),
            .cpu_req(cpu_req[g]), .cpu_we(cpu_we[g]),
            .cpu_addr(cpu_addr[g*ADDR_W +: ADDR_W]),
            .cpu_wdata(cpu_wdata[g*DATA_W +: DATA_W]),
            .cpu_done(cpu_done[g]),
            .cpu_rdata(cpu_rdata[g*DATA_W +: DATA_W]),
            .bus_req(breq[g]), .bus_gnt(gnt[g]),
            .req_rdx(rdx[g]), .req_addr(raddr[g]),
            .vic_wb(vwb[g]), .vic_addr(vaddr[g]), .vic_data(vdata[g]),
            .bus_valid(bus_valid), .bus_rdx(bus_rdx), .bus_addr(bus_addr),
            .fill_data(fill_data),
            .snp_own(sown[g]), .snp_data(sdata[g])
        );
    end

    assign bus_valid = |gnt;

    always_comb begin
        bus_rdx   = 1'b0;
        bus_addr  = '0;
        src_vwb   = 1'b0;
        src_vaddr = '0;
        src_vdata = '0;
        sup_hit   = 1'b0;
        sup_data  = '0;
        for (int i = 0; i < N_CPU; i++) begin
            if (gnt[i]) begin
                bus_rdx   = rdx[i];
                bus_addr  = raddr[i];
                src_vwb   = vwb[i];
                src_vaddr = vaddr[i];
                src_vdata = vdata[i];
            end
            if (sown[i]) begin
                sup_hit  = 1'b1;
                sup_data = sdata[i];
            end
        end
    end

    assign fill_data = sup_hit ? sup_data : mem_rd;

    coh_memory #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(bus_addr), .rd_data(mem_rd),
        .wa_en(bus_valid && src_vwb), .wa_addr(src_vaddr), .wa_data(src_vdata),
        .wb_en(bus_valid && sup_hit), .wb_addr(bus_addr), .wb_data(sup_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (bus_valid) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign bus_txn_count = cnt_q;
endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
    parameter int N     = 3,
    parameter int CW    = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic [N-1:0]  gnt,
    input logic [N-1:0]  breq,
    input logic [N-1:0]  sown,
    input logic [CW-1:0] count
);
    // R9: one grant at most per cycle
    p_gnt_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R9: grants only go to requesters
    p_gnt_to_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~breq) == '0);

    // R2: at most one owner of the bus address among snoopers
    p_single_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> $onehot0(sown));

    // R10: counter advances once per transaction
    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> count == $past(count) + CW'(1));

    // R10: counter holds on idle bus cycles
    p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> $stable(count));
endmodule

bind coh_snoop_top coh_checker #(.N(N_CPU), .CW(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .gnt(gnt),
    .breq(breq), .sown(sown), .count(bus_txn_count)
);

// File: tb/tb_coh_snoop_top.sv
`timescale 1ns/1ps
module tb_coh_snoop_top;
    localparam int N  = 3;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int CW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    cpu_req = '0;
    logic [N-1:0]    cpu_we = '0;
    logic [N*AW-1:0] cpu_addr = '0;
    logic [N*DW-1:0] cpu_wdata = '0;
    logic [N-1:0]    cpu_done;
    logic [N*DW-1:0] cpu_rdata;
    logic [CW-1:0]   bus_txn_count;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int exp_cnt = 0;

    always #2 clk = ~clk;

    coh_snoop_top #(.N_CPU(N), .ADDR_W(AW), .DATA_W(DW), .IDX_W(2), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .bus_txn_count(bus_txn_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // issue one access and wait for completion
    task automatic op(input int id, input bit we, input int addr, input int wd,
                      output int rd, output bit ok);
        @(negedge clk);
        cpu_req[id] = 1'b1;
        cpu_we[id]  = we;
        cpu_addr[id*AW +: AW]  = AW'(addr);
        cpu_wdata[id*DW +: DW] = DW'(wd);
        @(negedge clk);
        cpu_req[id] = 1'b0;
        ok = 1'b0;
        rd = 0;
        for (int t = 0; t < 100; t++) begin
            if (cpu_done[id]) begin
                ok = 1'b1;
                rd = int'(cpu_rdata[id*DW +: DW]);
                break;
            end
            @(negedge clk);
        end
    endtask

    // access with data and transaction-delta check
    task automatic acc(input string req, input int id, input bit we, input int addr,
                       input int wd, input bit chk_d, input int exp_d, input int dcnt);
        int rd;
        bit ok;
        op(id, we, addr, wd, rd, ok);
        check(ok, {req, " done"}, int'(ok), 1);
        check(cpu_done[id] == 1'b1, {req, " R12 done pulse"}, int'(cpu_done[id]), 1);
        if (chk_d) check(rd == exp_d, {req, " data"}, rd, exp_d);
        exp_cnt += dcnt;
        check(int'(bus_txn_count) == exp_cnt, {req, " R10 count"}, int'(bus_txn_count), exp_cnt);
        @(negedge clk);
        check(cpu_done[id] == 1'b0, {req, " R12 pulse width"}, int'(cpu_done[id]), 0);
    endtask

    task automatic t_reset();
        check(bus_txn_count == '0, "R1 count", int'(bus_txn_count), 0);
        check(cpu_done == '0, "R1 done", int'(cpu_done), 0);
    endtask

    task automatic t_read_basic();
        acc("R7 miss from zeroed memory (R1)", 0, 0, 5, 0, 1, 0, 1);
        acc("R3 hit on Shared", 0, 0, 5, 0, 1, 0, 0);
    endtask

    task automatic t_write_paths();
        acc("R5 write to Shared uses bus", 0, 1, 5, 'h1111, 1, 'h1111, 1);
        acc("R4 write hit Exclusive", 0, 1, 5, 'h2222, 1, 'h2222, 0);
        acc("R3 hit on Exclusive", 0, 0, 5, 0, 1, 'h2222, 0);
    endtask

    task automatic t_downgrade();
        acc("R7 supplied by dirty peer", 1, 0, 5, 0, 1, 'h2222, 1);
        acc("R6 downgraded holder read hit", 0, 0, 5, 0, 1, 'h2222, 0);
        acc("R6 downgraded holder write needs bus", 0, 1, 5, 'h2A2A, 1, 'h2A2A, 1);
        acc("R5 invalidated peer misses", 1, 0, 5, 0, 1, 'h2A2A, 1);
    endtask

    task automatic t_writeback_supply();
        acc("R8 evict clean 0", 0, 0, 9, 0, 1, 0, 1);
        acc("R8 evict clean 1", 1, 0, 9, 0, 1, 0, 1);
        acc("R8 memory holds supplied word", 2, 0, 5, 0, 1, 'h2A2A, 1);
    endtask

    task automatic t_evict_dirty();
        acc("R11 write miss", 2, 1, 13, 'h5555, 1, 'h5555, 1);
        acc("R4 second write local", 2, 1, 13, 'h5556, 1, 'h5556, 0);
        acc("R11 conflict evicts dirty victim", 2, 1, 9, 'h4444, 1, 'h4444, 1);
        acc("R11 victim word in memory", 0, 0, 13, 0, 1, 'h5556, 1);
        acc("R5 R7 invalidated peer gets owner word", 1, 0, 9, 0, 1, 'h4444, 1);
    endtask

    task automatic t_contention();
        int r0, r1, r2, v;
        bit k0, k1, k2;
        fork
            op(0, 1, 20, 'h7000, r0, k0);
            op(1, 1, 20, 'h7001, r1, k1);
        join
        check(k0 && k1, "R9 both writers complete", int'({k0, k1}), 3);
        exp_cnt += 2;
        @(negedge clk);
        check(int'(bus_txn_count) == exp_cnt, "R9 two transactions", int'(bus_txn_count), exp_cnt);
        op(2, 0, 20, 0, v, k2);
        exp_cnt += 1;
        check(k2 && (v == 'h7000 || v == 'h7001), "R2 single final value", v, 'h7000);
        fork
            op(0, 0, 33, 0, r0, k0);
            op(1, 0, 33, 0, r1, k1);
            op(2, 0, 33, 0, r2, k2);
        join
        check(k0 && k1 && k2, "R9 three readers complete", int'({k0, k1, k2}), 7);
        check(r0 == 0 && r1 == 0 && r2 == 0, "R7 shared reads", r0 | r1 | r2, 0);
        exp_cnt += 3;
        @(negedge clk);
        check(int'(bus_txn_count) == exp_cnt, "R9 three transactions", int'(bus_txn_count), exp_cnt);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_write_paths();
        t_downgrade();
        t_writeback_supply();
        t_evict_dirty();
        t_contention();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R12 actual=0x0 expected=0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule